// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block answers a three-wire serial memory bus (select, serial clock, data in, plus a data-out pin with its own enable) and behaves like a small electrically erasable memory. The serial lines are sampled by the system clock `clk`. A frame opens with a start bit. A two-bit command and an address follow, and write commands also carry a data field. Reads stream data back on the data-out pin. Programming commands launch a self-timed cycle whose length is a parameter given in system clocks.

A strap input picks the access width. With the strap high the array is seen as 16-bit words with an 8-bit address. With the strap low it is seen as bytes with a 9-bit address. Programming is locked after reset and stays locked until an unlock command arrives. While a cycle is running, raising select turns the data-out pin into a busy/ready flag.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A frame opens at the first rising serial clock edge, seen while select is high, at which data-in is high. Clock edges with select low, or with data-in low before the start bit, cause no operation.
- R2: After the start bit the bench sends two command bits and then the address, MSB first. The command codes are 10 read, 01 write, 11 erase and 00 extended. For extended commands the two top address bits choose the action: 11 unlock, 00 lock, 10 erase-all, 01 write-all.
- R3: With `org_i` high, accesses use 16-bit words and an 8-bit address. With it low, accesses use bytes and a 9-bit address, where byte 2k is the upper half of word k and byte 2k+1 is the lower half.
- R4: `do_oe_o` is low whenever `cs_i` is low. It is also low while a command is being clocked in and no status or read data is due.
- R5: A read drives a 0 at the rising edge that carries the last address bit. The following rising edges then drive the data, MSB first.
- R6: While select stays high after a read item, the following locations stream out with no further zero bit. The address wraps from the last location to 0.
- R7: After reset programming is locked. Write and erase commands change nothing until an unlock command is executed, and a lock command blocks them again. Reads work in both states.
- R8: A write stores its data field and an erase sets every bit of the location to 1. The cycle starts on the select fall that follows the final bit. If select falls before the final bit, nothing changes.
- R9: While a cycle runs, a high `cs_i` gives `do_oe_o`=1 with `do_o`=0 (busy). Once `PROG_CYCLES` clocks have passed, `do_o` reads 1 (ready).
- R10: Erase-all and write-all apply to every location. In byte mode write-all copies its byte into both halves of every word.
- R11: A frame that starts while a programming cycle is running is ignored entirely.
- R12: After reset every location reads all ones and `do_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Width strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out / busy-ready flag |
| do_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
Two functions can land on the same serial clock edge: the ready flag on the data-out pin and the start of a new frame. The bench waits for ready, keeps select high, and clocks a read command straight away. At the start-bit edge the status flag has to give way to the command decode. The scoreboard then expects the leading zero and the read data exactly where a read with a fresh select would put them. The bench also issues a lock command while a cycle is still busy and shows that it was dropped, because a later write still takes effect.

// File: rtl/tw_pkg.sv
package tw_pkg;
   timeunit 1ns; timeprecision 1ps;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_ARM, ST_DONE
   } tw_state_e;

   localparam logic [1:0] CMD_EXT = 2'b00;
   localparam logic [1:0] CMD_WR  = 2'b01;
   localparam logic [1:0] CMD_RD  = 2'b10;
   localparam logic [1:0] CMD_ER  = 2'b11;

   localparam logic [1:0] EXT_LOCK = 2'b00;
   localparam logic [1:0] EXT_WRA  = 2'b01;
   localparam logic [1:0] EXT_ERA  = 2'b10;
   localparam logic [1:0] EXT_UNLK = 2'b11;
endpackage

// File: rtl/tw_ptimer.sv
module tw_ptimer #(
   parameter int PROG_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done
);
   timeunit 1ns; timeprecision 1ps;

   localparam int TW = $clog2(PROG_CYCLES + 1);
   localparam logic [TW-1:0] LAST = TW'(PROG_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   assign done = busy & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (go && !busy) begin
         busy  <= 1'b1;
         cnt_q <= '0;
      end else if (done) begin
         busy  <= 1'b0;
      end else if (busy) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end
endmodule

// File: rtl/tw_store.sv
module tw_store #(
   parameter int WORD_AW        = 8,
   parameter int WORD_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_all,
   input  logic              go_bmode,
   input  logic [WORD_AW:0]  go_addr,
   input  logic [WORD_W-1:0] go_data,
   input  logic              commit,
   input  logic [WORD_AW:0]  rd_addr,
   input  logic              rd_bmode,
   output logic [WORD_W-1:0] rd_data
);
   timeunit 1ns; timeprecision 1ps;

   localparam int DEPTH  = 1 << WORD_AW;
   localparam int BYTE_W = WORD_W / 2;
   localparam int BAW    = WORD_AW + 1;

   logic              p_all, p_bm;
   logic [BAW-1:0]    p_addr;
   logic [WORD_W-1:0] p_data;
   logic [WORD_AW-1:0] p_word;
   logic [DEPTH-1:0][WORD_W-1:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_all  <= 1'b0;
         p_bm   <= 1'b0;
         p_addr <= '0;
         p_data <= '0;
      end else if (go) begin
         p_all  <= go_all;
         p_bm   <= go_bmode;
         p_addr <= go_addr;
         p_data <= go_data;
      end
   end

   assign p_word = p_bm ? p_addr[BAW-1:1] : p_addr[WORD_AW-1:0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic              hit;
      logic [WORD_W-1:0] nxt;
      logic [WORD_W-1:0] cell_q;

      assign hit = commit && (p_all || (p_word == WORD_AW'(i)));

      always_comb begin
         nxt = cell_q;
         if (!p_bm)        nxt = p_data;
         else if (p_all)   nxt = {2{p_data[BYTE_W-1:0]}};
         else if (!p_addr[0]) nxt[WORD_W-1:BYTE_W] = p_data[BYTE_W-1:0];
         else              nxt[BYTE_W-1:0] = p_data[BYTE_W-1:0];
      end

      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= '1;
            else if (hit) cell_q <= nxt;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) cell_q <= nxt;
         end
      end

      assign cells[i] = cell_q;
   end

   logic [WORD_AW-1:0] r_word;
   logic [WORD_W-1:0]  r_full;

   assign r_word = rd_bmode ? rd_addr[BAW-1:1] : rd_addr[WORD_AW-1:0];
   assign r_full = cells[r_word];

   always_comb begin
      if (!rd_bmode)     rd_data = r_full;
      else if (rd_addr[0]) rd_data = {r_full[BYTE_W-1:0], {BYTE_W{1'b0}}};
      else               rd_data = {r_full[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
   end
endmodule

// File: rtl/tw_frame.sv
module tw_frame
   import tw_pkg::*;
#(
   parameter int WORD_AW = 8,
   parameter int WORD_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sck,
   input  logic              di,
   input  logic              org,
   input  logic              busy,
   input  logic [WORD_W-1:0] rd_word,
   output logic [WORD_AW:0]  rd_addr,
   output logic              rd_bmode,
   output logic              go,
   output logic              go_all,
   output logic              go_bmode,
   output logic [WORD_AW:0]  go_addr,
   output logic [WORD_W-1:0] go_data,
   output logic              wr_en,
   output logic              rd_active,
   output logic              dout,
   output logic              stat_vis,
   output logic              idle
);
   timeunit 1ns; timeprecision 1ps;

   localparam int BAW    = WORD_AW + 1;
   localparam int BYTE_W = WORD_W / 2;
   localparam int CW     = $clog2(BAW + WORD_W + 2);

   tw_state_e         st_q;
   logic              sck_q, cs_q, rise, cs_fall, start_ok;
   logic [1:0]        opc_q, ext;
   logic [BAW-1:0]    adr_q, adr_nx, adr_inc;
   logic [WORD_W-1:0] dat_q, rsh_q;
   logic [CW-1:0]     cnt_q, aw_n, dw_n;
   logic              bm_q, all_q, en_q, dout_q, stat_q;

   assign rise     = sck & ~sck_q;
   assign cs_fall  = cs_q & ~cs;
   assign start_ok = (st_q == ST_IDLE) & rise & cs & di & ~busy;

   assign aw_n    = bm_q ? CW'(BAW)    : CW'(WORD_AW);
   assign dw_n    = bm_q ? CW'(BYTE_W) : CW'(WORD_W);
   assign adr_nx  = {adr_q[BAW-2:0], di};
   assign adr_inc = bm_q ? adr_q + BAW'(1)
                         : {1'b0, adr_q[WORD_AW-1:0] + WORD_AW'(1)};
   assign ext     = bm_q ? adr_nx[BAW-1 -: 2] : adr_nx[WORD_AW-1 -: 2];

   assign rd_addr   = (st_q == ST_RD) ? adr_inc : adr_nx;
   assign rd_bmode  = bm_q;
   assign go        = cs_fall & (st_q == ST_ARM) & en_q;
   assign go_all    = all_q;
   assign go_bmode  = bm_q;
   assign go_addr   = adr_q;
   assign go_data   = bm_q ? {{BYTE_W{1'b0}}, dat_q[BYTE_W-1:0]} : dat_q;
   assign wr_en     = en_q;
   assign rd_active = (st_q == ST_RD);
   assign dout      = dout_q;
   assign idle      = (st_q == ST_IDLE);
   assign stat_vis  = stat_q & (st_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b0;
      end else begin
         sck_q <= sck;
         cs_q  <= cs;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         opc_q  <= '0;
         adr_q  <= '0;
         dat_q  <= '0;
         rsh_q  <= '0;
         cnt_q  <= '0;
         bm_q   <= 1'b0;
         all_q  <= 1'b0;
         en_q   <= 1'b0;
         dout_q <= 1'b0;
         stat_q <= 1'b0;
      end else if (cs_fall) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         if (go)         stat_q <= 1'b1;
         else if (!busy) stat_q <= 1'b0;
      end else if (start_ok) begin
         st_q   <= ST_OPC;
         cnt_q  <= '0;
         adr_q  <= '0;
         bm_q   <= ~org;
         stat_q <= 1'b0;
      end else if (rise && cs) begin
         unique case (st_q)
            ST_OPC: begin
               opc_q <= {opc_q[0], di};
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(1)) begin
                  st_q  <= ST_ADR;
                  cnt_q <= '0;
               end
            end
            ST_ADR: begin
               adr_q <= adr_nx;
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == aw_n - CW'(1)) begin
                  cnt_q <= '0;
                  unique case (opc_q)
                     CMD_RD: begin
                        st_q   <= ST_RD;
                        rsh_q  <= rd_word;
                        dout_q <= 1'b0;
                     end
                     CMD_WR: begin
                        all_q <= 1'b0;
                        st_q  <= ST_DAT;
                     end
                     CMD_ER: begin
                        all_q <= 1'b0;
                        dat_q <= '1;
                        st_q  <= ST_ARM;
                     end
                     default: begin
                        unique case (ext)
                           EXT_UNLK: begin en_q <= 1'b1; st_q <= ST_DONE; end
                           EXT_LOCK: begin en_q <= 1'b0; st_q <= ST_DONE; end
                           EXT_ERA:  begin all_q <= 1'b1; dat_q <= '1; st_q <= ST_ARM; end
                           default:  begin all_q <= 1'b1; st_q <= ST_DAT; end
                        endcase
                     end
                  endcase
               end
            end
            ST_DAT: begin
               dat_q <= {dat_q[WORD_W-2:0], di};
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == dw_n - CW'(1)) st_q <= ST_ARM;
            end
            ST_RD: begin
               if (cnt_q == dw_n) begin
                  dout_q <= rd_word[WORD_W-1];
                  rsh_q  <= {rd_word[WORD_W-2:0], 1'b0};
                  cnt_q  <= CW'(1);
                  adr_q  <= adr_inc;
               end else begin
                  dout_q <= rsh_q[WORD_W-1];
                  rsh_q  <= {rsh_q[WORD_W-2:0], 1'b0};
                  cnt_q  <= cnt_q + CW'(1);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
   parameter int WORD_AW        = 8,
   parameter int WORD_W         = 16,
   parameter int PROG_CYCLES    = 200,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic di_i,
   input  logic org_i,
   output logic do_o,
   output logic do_oe_o
);
   timeunit 1ns; timeprecision 1ps;

   if (WORD_AW < 2)        begin : g_bad_aw  $error("WORD_AW must be at least 2"); end
   if (WORD_W < 4 || (WORD_W % 2) != 0)
                           begin : g_bad_w   $error("WORD_W must be even and at least 4"); end
   if (PROG_CYCLES < 2)    begin : g_bad_pc  $error("PROG_CYCLES must be at least 2"); end

   logic              busy, done, go, go_all, go_bmode, rd_bmode;
   logic              wr_en, rd_active, dout, stat_vis, fr_idle;
   logic [WORD_AW:0]  go_addr, rd_addr;
   logic [WORD_W-1:0] go_data, rd_word;

   tw_frame #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) u_frame (
      .clk, .rst_n, .cs(cs_i), .sck(sck_i), .di(di_i), .org(org_i), .busy,
      .rd_word, .rd_addr, .rd_bmode, .go, .go_all, .go_bmode, .go_addr,
      .go_data, .wr_en, .rd_active, .dout, .stat_vis, .idle(fr_idle)
   );

   tw_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk, .rst_n, .go, .busy, .done
   );

   tw_store #(.WORD_AW(WORD_AW), .WORD_W(WORD_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk, .rst_n, .go, .go_all, .go_bmode, .go_addr, .go_data,
      .commit(done), .rd_addr, .rd_bmode, .rd_data(rd_word)
   );

   assign do_oe_o = cs_i & (rd_active | stat_vis);
   assign do_o    = rd_active ? dout : ~busy;
endmodule

// File: rtl/tw_eeprom_sva.sv
module tw_eeprom_sva #(
   parameter int PROG_CYCLES = 200
) (
   input logic clk,
   input logic rst_n,
   input logic cs_i,
   input logic do_o,
   input logic do_oe_o,
   input logic busy,
   input logic wr_en,
   input logic rd_active,
   input logic fr_idle
);
   timeunit 1ns; timeprecision 1ps;

   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   a_r4_quiet_without_select: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |-> !do_oe_o);

   a_r5_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_active) |-> !do_o);

   a_r7_cycle_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en));

   a_r8_cycle_after_select_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(cs_i));

   a_r9_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_len == PROG_CYCLES);

   a_r11_busy_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fr_idle) |=> fr_idle);
endmodule

bind tw_eeprom_slave tw_eeprom_sva #(.PROG_CYCLES(PROG_CYCLES)) u_sva (
   .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .do_o(do_o), .do_oe_o(do_oe_o),
   .busy(busy), .wr_en(wr_en), .rd_active(rd_active), .fr_idle(fr_idle)
);

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;
   timeunit 1ns; timeprecision 1ps;

   localparam int PROG = 200;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
   logic do_o, do_oe;
   int   n_tests = 0, n_fail = 0;
   logic [15:0] model [256];
   logic  exp_q [$];
   string tag_q [$];
   event  ev_smp;
   logic  m_e;
   string m_t;

   always #2 clk = ~clk;

   tw_eeprom_slave #(.PROG_CYCLES(PROG)) i_tw_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di), .org_i(org),
      .do_o(do_o), .do_oe_o(do_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every sampled serial edge with a pending item is judged
   always @(ev_smp) begin
      if (exp_q.size() > 0) begin
         m_e = exp_q.pop_front();
         m_t = tag_q.pop_front();
         chk(m_t, {30'd0, do_oe, do_o}, {30'd0, 1'b1, m_e});
      end
   end

   function automatic int aw();  return org ? 8 : 9;  endfunction
   function automatic int dw();  return org ? 16 : 8; endfunction
   function automatic logic [15:0] item(input int a);
      logic [15:0] w;
      if (org) return model[a & 255];
      w = model[(a & 511) >> 1];
      return a[0] ? {8'h0, w[7:0]} : {8'h0, w[15:8]};
   endfunction
   task automatic put(input int a, input logic [15:0] d);
      if (org) model[a & 255] = d;
      else if (a[0]) model[(a & 511) >> 1][7:0] = d[7:0];
      else model[(a & 511) >> 1][15:8] = d[7:0];
   endtask

   task automatic sbit(input logic b);
      @(negedge clk); di = b;
      @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk);
      -> ev_smp;
      @(negedge clk); sck = 1'b0;
   endtask
   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(v[i]);
   endtask
   task automatic cs_up();
      @(negedge clk); cs = 1'b1;
      @(negedge clk);
   endtask
   task automatic cs_down();
      @(negedge clk); cs = 1'b0; di = 1'b0;
      repeat (2) @(negedge clk);
   endtask
   task automatic push(input logic b, input string t);
      exp_q.push_back(b); tag_q.push_back(t);
   endtask

   // read n items from a; R5 dummy zero then MSB-first data, R6 streaming
   task automatic rd(input int a, input int n, input string t);
      logic [15:0] w;
      if (!cs) cs_up();
      sbit(1'b1); send(32'b10, 2);
      send(a >> 1, aw() - 1);
      push(1'b0, "R5");
      sbit(a[0]);
      for (int k = 0; k < n; k++) begin
         w = item(a + k);
         for (int i = dw() - 1; i >= 0; i--) begin
            push(w[i], t);
            sbit(1'b0);
         end
      end
      cs_down();
      chk("R4 idle after read", {31'd0, do_oe}, 32'd0);
   endtask

   task automatic prog(input logic [1:0] op, input int a, input logic [15:0] d, input bit hasd);
      cs_up();
      sbit(1'b1); send(op, 2); send(a, aw());
      if (hasd) send(d, dw());
      chk("R4 no drive during command", {31'd0, do_oe}, 32'd0);
      cs_down();
   endtask
   function automatic int extaddr(input logic [1:0] code);
      return int'(code) << (aw() - 2);
   endfunction

   task automatic wait_ready(input bit keep);
      int n;
      cs_up(); @(negedge clk);
      chk("R9 busy flag", {30'd0, do_oe, do_o}, 32'b10);
      n = 0;
      while (do_o !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      chk("R9 ready flag", {30'd0, do_oe, do_o}, 32'b11);
      chk("R9 cycle bounded", {31'd0, n <= PROG}, 32'd1);
      if (!keep) cs_down();
   endtask

   task automatic no_status(input string t);
      cs_up(); @(negedge clk);
      chk(t, {31'd0, do_oe}, 32'd0);
      cs_down();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
      repeat (5) @(negedge clk);
      chk("R12 reset oe", {31'd0, do_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      no_status("R12 no status after reset");

      // R1: clocks with select low, and leading zeros, do nothing
      for (int i = 0; i < 3; i++) sbit(1'b1);
      cs_up(); sbit(1'b0); sbit(1'b0);
      rd(0, 1, "R1 R12 read after leading zeros");

      // R7: locked after reset
      prog(2'b01, 5, 16'h1234, 1);
      no_status("R7 locked write starts no cycle");
      rd(5, 1, "R7 locked write kept data");

      prog(2'b00, extaddr(2'b11), 0, 0);   // R2 unlock
      prog(2'b01, 5, 16'h1234, 1); put(5, 16'h1234); wait_ready(0);
      prog(2'b01, 6, 16'hABCD, 1); put(6, 16'hABCD); wait_ready(0);
      prog(2'b01, 7, 16'h0F0F, 1); put(7, 16'h0F0F); wait_ready(0);
      rd(5, 3, "R6 R8 sequential words");
      prog(2'b01, 255, 16'h5555, 1); put(255, 16'h5555); wait_ready(0);
      rd(255, 2, "R6 wrap to zero");

      // R3: byte mode
      org = 1'b0;
      prog(2'b01, 10, 16'h0077, 1); put(10, 16'h0077); wait_ready(0);
      rd(10, 2, "R3 byte read");
      org = 1'b1;
      rd(5, 1, "R3 word view of bytes");

      // R8: erase and abort
      prog(2'b11, 6, 0, 0); put(6, 16'hFFFF); wait_ready(0);
      rd(6, 1, "R8 erase");
      cs_up(); sbit(1'b1); send(32'b01, 2); send(7, 8); send(8'hAA, 8); cs_down();
      no_status("R8 aborted frame starts no cycle");
      rd(7, 1, "R8 aborted frame kept data");

      // R11: lock frame sent while busy is ignored
      prog(2'b01, 8, 16'h1111, 1); put(8, 16'h1111);
      cs_up(); @(negedge clk);
      chk("R11 busy at frame", {30'd0, do_oe, do_o}, 32'b10);
      sbit(1'b1); send(32'b00, 2); send(extaddr(2'b00), 8);
      cs_down();
      wait_ready(0);
      prog(2'b01, 9, 16'h2222, 1); put(9, 16'h2222); wait_ready(0);
      rd(8, 2, "R11 lock while busy ignored");

      // ready flag and a new start bit on the same select
      prog(2'b01, 10, 16'h3C3C, 1); put(10, 16'h3C3C);
      wait_ready(1);
      rd(10, 1, "R9 R5 read follows ready flag");

      // R10: bulk operations
      prog(2'b00, extaddr(2'b01), 16'h5A5A, 1);
      for (int i = 0; i < 256; i++) model[i] = 16'h5A5A;
      wait_ready(0);
      rd(0, 2, "R10 write-all"); rd(200, 1, "R10 write-all");
      prog(2'b00, extaddr(2'b10), 0, 0);
      for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
      wait_ready(0);
      rd(100, 1, "R10 erase-all");
      org = 1'b0;
      prog(2'b00, extaddr(2'b01), 16'h00C3, 1);
      for (int i = 0; i < 256; i++) model[i] = 16'hC3C3;
      wait_ready(0);
      rd(7, 1, "R10 byte write-all");
      org = 1'b1;
      rd(3, 1, "R10 byte write-all word view");

      // R7: lock again
      prog(2'b00, extaddr(2'b00), 0, 0);
      prog(2'b01, 20, 16'h9999, 1);
      no_status("R7 relocked write starts no cycle");
      rd(20, 1, "R7 read while locked");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule